// File: doc/BRIEF.md
# Receive FIFO Automatic RTS Flow Controller

This block produces the active-low RTS modem line for a UART receiver from the fill count of its 16-entry receive FIFO. In automatic mode it throttles the remote transmitter with hysteresis taken from the trigger ladder. RTS goes high when the fill reaches the ladder step above the programmed trigger. It goes low again only when the fill falls beneath the step below the trigger. The same programmed trigger also drives a level-type receive interrupt request.

When automatic mode is off, the pin simply copies a software-held RTS level. The FIFO storage, the serial receiver and the register interface sit outside the block. Both outputs are registered and reflect the inputs sampled at the previous rising clock edge.

Top module: `rx_auto_rts`

## Requirements
- R1: While `rst` is high at a clock edge, `rts_n` is 1 and `rx_trig_irq` is 0 after that edge.
- R2: `trig_sel` picks the trigger level: 0 gives 1 byte, 1 gives 4, 2 gives 8 and 3 gives 14.
- R3: `rx_trig_irq` is 1 one cycle after a cycle in which `fifo_count` is at or above the selected trigger level. It is 0 one cycle after a cycle in which the count is below it. This holds whatever the value of `auto_rts_en`.
- R4: With `auto_rts_en` = 1, a count at or above the upper threshold drives `rts_n` to 1 on the next cycle. The upper threshold is 4, 8, 14 or 16 for `trig_sel` 0, 1, 2 or 3.
- R5: With `auto_rts_en` = 1, a count below the lower threshold drives `rts_n` to 0 on the next cycle. The lower threshold is 1, 1, 4 or 8 for `trig_sel` 0, 1, 2 or 3, so trigger 1 releases only when the FIFO is empty.
- R6: With `auto_rts_en` = 1 in two consecutive cycles, and the second cycle's count between the thresholds (lower ≤ count < upper), `rts_n` keeps its value.
- R7: With `auto_rts_en` = 0, `rts_n` equals the `sw_rts_n` value of the previous cycle.
- R8: While automatic mode is off, the throttle state is cleared. On re-enabling with a count between the thresholds, `rts_n` therefore goes to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fifo_count | input | 5 | Current receive FIFO fill, 0 to 16 |
| trig_sel | input | 2 | Trigger level select (ladder index) |
| auto_rts_en | input | 1 | 1 enables automatic RTS flow control |
| sw_rts_n | input | 1 | Software RTS pin level used when automatic mode is off |
| rts_n | output | 1 | RTS pin level, active low (1 = stop sending) |
| rx_trig_irq | output | 1 | Receive trigger interrupt request, level |

## Verification
A corrupted throttle state shows up at `rts_n` one cycle after the count enters the band between the thresholds, where the pin must hold. It then persists until the count crosses a threshold. A wrong threshold decode shows up as an early or late pin edge on a slow up-and-down ramp for that select value, in the cycle right after the crossing count. Interrupt errors show up on `rx_trig_irq` one cycle after the count passes the trigger.

// File: rtl/rx_auto_rts_pkg.sv
package rx_auto_rts_pkg;
  localparam int unsigned SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    TRIG_STEP0 = 2'd0,
    TRIG_STEP1 = 2'd1,
    TRIG_STEP2 = 2'd2,
    TRIG_STEP3 = 2'd3
  } trig_sel_e;
endpackage

// File: rtl/rx_auto_rts_ladder.sv
module rx_auto_rts_ladder
  import rx_auto_rts_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = 5,
  parameter int unsigned LVL0  = 1,
  parameter int unsigned LVL1  = 4,
  parameter int unsigned LVL2  = 8,
  parameter int unsigned LVL3  = 14
) (
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] trig,
  output logic [CNT_W-1:0] upper,
  output logic [CNT_W-1:0] lower
);
  localparam logic [CNT_W-1:0] T0 = CNT_W'(LVL0);
  localparam logic [CNT_W-1:0] T1 = CNT_W'(LVL1);
  localparam logic [CNT_W-1:0] T2 = CNT_W'(LVL2);
  localparam logic [CNT_W-1:0] T3 = CNT_W'(LVL3);
  localparam logic [CNT_W-1:0] TFULL = CNT_W'(DEPTH);
  // lowest step releases only on empty: count < 1
  localparam logic [CNT_W-1:0] TEMPTY = CNT_W'(1);

  always_comb begin
    unique case (trig_sel_e'(sel))
      TRIG_STEP0: begin trig = T0; upper = T1;    lower = TEMPTY; end
      TRIG_STEP1: begin trig = T1; upper = T2;    lower = T0;     end
      TRIG_STEP2: begin trig = T2; upper = T3;    lower = T1;     end
      default:    begin trig = T3; upper = TFULL; lower = T2;     end
    endcase
  end
endmodule

// File: rtl/rx_auto_rts_hyst.sv
module rx_auto_rts_hyst #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             auto_en,
  input  logic             sw_rts_n,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] upper,
  input  logic [CNT_W-1:0] lower,
  output logic             rts_n
);
  logic throttle_q;
  logic throttle_nxt;

  always_comb begin
    throttle_nxt = throttle_q;
    if (count >= upper)     throttle_nxt = 1'b1;
    else if (count < lower) throttle_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      throttle_q <= 1'b1;
      rts_n      <= 1'b1;
    end else if (auto_en) begin
      throttle_q <= throttle_nxt;
      rts_n      <= throttle_nxt;
    end else begin
      throttle_q <= 1'b0;
      rts_n      <= sw_rts_n;
    end
  end
endmodule

// File: rtl/rx_auto_rts_irq.sv
module rx_auto_rts_irq #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] trig,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (count >= trig);
  end
endmodule

// File: rtl/rx_auto_rts.sv
module rx_auto_rts
  import rx_auto_rts_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LVL0  = 1,
  parameter int unsigned LVL1  = 4,
  parameter int unsigned LVL2  = 8,
  parameter int unsigned LVL3  = 14,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic [SEL_W-1:0] trig_sel,
  input  logic             auto_rts_en,
  input  logic             sw_rts_n,
  output logic             rts_n,
  output logic             rx_trig_irq
);
  logic [CNT_W-1:0] trig_lvl;
  logic [CNT_W-1:0] upper_lvl;
  logic [CNT_W-1:0] lower_lvl;

  rx_auto_rts_ladder #(
    .DEPTH(DEPTH), .CNT_W(CNT_W),
    .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)
  ) u_ladder (
    .sel   (trig_sel),
    .trig  (trig_lvl),
    .upper (upper_lvl),
    .lower (lower_lvl)
  );

  rx_auto_rts_hyst #(.CNT_W(CNT_W)) u_hyst (
    .clk      (clk),
    .rst      (rst),
    .auto_en  (auto_rts_en),
    .sw_rts_n (sw_rts_n),
    .count    (fifo_count),
    .upper    (upper_lvl),
    .lower    (lower_lvl),
    .rts_n    (rts_n)
  );

  rx_auto_rts_irq #(.CNT_W(CNT_W)) u_irq (
    .clk   (clk),
    .rst   (rst),
    .count (fifo_count),
    .trig  (trig_lvl),
    .irq   (rx_trig_irq)
  );
endmodule

// File: rtl/rx_auto_rts_chk.sv
module rx_auto_rts_chk #(
  parameter int unsigned CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] fifo_count,
  input logic [1:0]       trig_sel,
  input logic             auto_rts_en,
  input logic             sw_rts_n,
  input logic             rts_n,
  input logic             rx_trig_irq
);
  int unsigned up_c, lo_c, tr_c;
  always_comb begin
    case (trig_sel)
      2'd0:    begin tr_c = 1;  up_c = 4;  lo_c = 1; end
      2'd1:    begin tr_c = 4;  up_c = 8;  lo_c = 1; end
      2'd2:    begin tr_c = 8;  up_c = 14; lo_c = 4; end
      default: begin tr_c = 14; up_c = 16; lo_c = 8; end
    endcase
  end

  logic above_c, below_c, trig_c;
  assign above_c = int'(fifo_count) >= int'(up_c);
  assign below_c = int'(fifo_count) < int'(lo_c);
  assign trig_c  = int'(fifo_count) >= int'(tr_c);

  a_r1_reset_state: assert property (@(posedge clk) rst |=> (rts_n && !rx_trig_irq));
  a_r3_irq_set: assert property (@(posedge clk) disable iff (rst) trig_c |=> rx_trig_irq);
  a_r3_irq_clear: assert property (@(posedge clk) disable iff (rst) !trig_c |=> !rx_trig_irq);
  a_r4_deassert: assert property (@(posedge clk) disable iff (rst) (auto_rts_en && above_c) |=> rts_n);
  a_r5_reassert: assert property (@(posedge clk) disable iff (rst) (auto_rts_en && below_c) |=> !rts_n);
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (auto_rts_en && $past(auto_rts_en) && !above_c && !below_c) |=> (rts_n == $past(rts_n)));
  a_r7_manual: assert property (@(posedge clk) disable iff (rst) !auto_rts_en |=> (rts_n == $past(sw_rts_n)));
endmodule

bind rx_auto_rts rx_auto_rts_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .fifo_count(fifo_count), .trig_sel(trig_sel),
  .auto_rts_en(auto_rts_en), .sw_rts_n(sw_rts_n), .rts_n(rts_n), .rx_trig_irq(rx_trig_irq)
);

// File: tb/rx_auto_rts_bench.sv
module rx_auto_rts_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] fifo_count = '0;
  logic [1:0] trig_sel = '0;
  logic       auto_rts_en = 1'b0;
  logic       sw_rts_n = 1'b1;
  logic       rts_n;
  logic       rx_trig_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit m_thr = 1'b1;
  bit m_pin = 1'b1;

  always #10 clk = ~clk;

  rx_auto_rts u_rx_auto_rts (
    .clk(clk), .rst(rst), .fifo_count(fifo_count), .trig_sel(trig_sel),
    .auto_rts_en(auto_rts_en), .sw_rts_n(sw_rts_n),
    .rts_n(rts_n), .rx_trig_irq(rx_trig_irq)
  );

  function automatic int trig_of(int s);
    return (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
  endfunction
  function automatic int upper_of(int s);
    return (s == 3) ? 16 : trig_of(s + 1);
  endfunction
  function automatic int lower_of(int s);
    return (s == 0) ? 1 : trig_of(s - 1);
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b (sel=%0d count=%0d en=%0b)",
               req, act, exp, trig_sel, fifo_count, auto_rts_en);
    end
  endtask

  task automatic step(int cnt, int s, bit en, bit sw);
    string preq;
    fifo_count  = 5'(cnt);
    trig_sel    = 2'(s);
    auto_rts_en = en;
    sw_rts_n    = sw;
    if (!en) begin
      m_thr = 1'b0; m_pin = sw; preq = "R7";
    end else if (cnt >= upper_of(s)) begin
      m_thr = 1'b1; m_pin = 1'b1; preq = "R4";
    end else if (cnt < lower_of(s)) begin
      m_thr = 1'b0; m_pin = 1'b0; preq = "R5";
    end else begin
      m_pin = m_thr; preq = "R6";
    end
    @(posedge clk);
    @(negedge clk);
    check(preq, rts_n, m_pin);
    check("R3/R2 irq", rx_trig_irq, cnt >= trig_of(s));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rts", rts_n, 1'b1);
    check("R1 irq", rx_trig_irq, 1'b0);
    rst = 1'b0;
    // R4 R5 R6 R2: full up/down ramps for each ladder step
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c <= 16; c++) step(c, s, 1'b1, 1'b1);
      for (int c = 16; c >= 0; c--) step(c, s, 1'b1, 1'b1);
    end
    // R6: wiggle inside the band after throttling
    step(16, 1, 1'b1, 1'b0);
    for (int c = 7; c >= 1; c--) step(c, 1, 1'b1, 1'b0);
    step(3, 1, 1'b1, 1'b0);
    step(0, 1, 1'b1, 1'b0);
    for (int c = 1; c <= 7; c++) step(c, 1, 1'b1, 1'b0);
    // R7: manual mode with varying counts and levels
    for (int i = 0; i < 32; i++) step(i % 17, i % 4, 1'b0, i[0] ^ i[2]);
    // R8: throttle cleared by disable, re-enable inside band
    step(16, 2, 1'b1, 1'b1);
    step(10, 2, 1'b0, 1'b1);
    step(10, 2, 1'b1, 1'b1);
    check("R8 reenable low", rts_n, 1'b0);
    // R1: reset mid-run with throttled pin and irq set
    step(16, 3, 1'b1, 1'b0);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 rts midrun", rts_n, 1'b1);
    check("R1 irq midrun", rx_trig_irq, 1'b0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule